// File: doc/BRIEF.md
# Pipelined Burst Static RAM

A clocked static RAM model with registered inputs and a registered read path, intended as the word store behind a cache controller or a packet buffer. Every control, address and write-data input is sampled on the rising clock edge. An access starts when one of two address strobes is seen. After that start, the low two address bits are driven by an internal 2-bit counter, so a four-beat burst needs only one address. The counter follows either a XOR (interleaved) order or a wrap-around increment (linear) order, chosen by `mode_i`. An advance input steps the counter each cycle. Holding advance inactive keeps the burst on its current address.

Read data goes through one output register and appears in the cycle after the read was captured. The data pins are modelled as a data bus plus a drive flag, `rd_drive_o`. The drive flag drops one cycle after a deselect, and it drops at once whenever the output enable is inactive. Writes go through per-byte lane enables or a global write input. A sleep input freezes all state, and the array contents are kept while it is high.

Top module: `sync_burst_sram`

## Requirements
- R1: The part is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A start cycle with any other combination deselects it, and `rd_drive_o` is 0 from the next cycle.
- R2: A start cycle occurs when `ads_ctl_ni`=0, or when `ads_cpu_ni`=0 with `ce1_ni`=0. If `ce1_ni`=1, a low `ads_cpu_ni` is ignored. A start through `ads_cpu_ni` is always a read. A start through `ads_ctl_ni` alone is a write when R6 says so.
- R3: When `mode_i`=1, the beats after a start at low bits s use the low bits s^1, s^2 and s^3. The upper address bits keep the loaded value.
- R4: When `mode_i`=0, the low two bits step by +1 modulo 4 from s. The upper bits are unchanged.
- R5: In a running burst, `adv_ni`=0 moves to the next beat address. `adv_ni`=1 accesses the current address again (suspend).
- R6: A cycle is a write when `gw_ni`=0, or when `bwe_ni`=0 and at least one `bw_ni` bit is 0. `bwe_ni`=0 with all `bw_ni`=1 and `gw_ni`=1 is a read. A write cycle never drives the outputs in the following cycle.
- R7: `gw_ni`=0 writes all lanes. Otherwise lane k, which is data bits [8k+7:8k], is written only when `bw_ni[k]`=0.
- R8: A read captured at a clock edge places the word on `rdata_o` with `rd_drive_o`=1 from that edge until the next edge.
- R9: After reset, and after a deselect, the outputs stay undriven until the next selected start cycle. Cycles without a strobe do not restart the burst.
- R10: `oe_ni`=1 forces `rd_drive_o`=0 at once, whatever the pipeline holds.
- R11: While `sleep_i`=1, no read, write, address or burst update takes effect and `rdata_o` holds its value. Operation resumes from the same state when `sleep_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| ads_cpu_ni | input | 1 | Processor-side address strobe, active low |
| ads_ctl_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Chip enable 1, active low |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write master enable, active low |
| bw_ni | input | LANES | Per-lane write enables, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Freeze operation, contents kept |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| rd_drive_o | output | 1 | High when the data outputs are driven |

## Verification
The hardest situations to reach are the ones where inputs conflict inside a running burst. Examples are a processor strobe arriving while `ce1_ni` is high, a start at a non-zero low address with a suspend in the middle of the burst, and a sleep pulse in the middle of a burst. Directed sequences first fill the array with known words. They then walk both burst orders from odd start offsets, insert suspends, lane-masked writes and masked reads, and apply those conflict cases. After that, long seeded random runs in each mode mix strobes, deselects, sleep and output-enable toggling. These runs are checked every cycle against a bench model built from the requirements.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned BURST_W = 2;

  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               interleave
  );
    return interleave ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] acc_addr_o
);
  logic [AW-1:0]      base_q;
  logic [BURST_W-1:0] beat_q, beat_n;

  assign beat_n = step_i ? beat_q + 1'b1 : beat_q;

  always_comb begin
    if (load_i) acc_addr_o = addr_i;
    else acc_addr_o = {base_q[AW-1:BURST_W], burst_low(base_q[BURST_W-1:0], beat_n, mode_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      beat_q <= '0;
    end else begin
      beat_q <= beat_n;
    end
  end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [LANES-1:0]    lane_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] cell_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[k]) cell_q[addr_i] <= wdata_i[k*LW +: LW];
    end
    assign rdata_o[k*LW +: LW] = cell_q[addr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             ads_cpu_ni,
  input  logic             ads_ctl_ni,
  input  logic             adv_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             mode_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rd_drive_o
);
  logic sel, cpu_go, ctl_go, start, is_wr;
  logic load, desel, cont, step, rd_en, wr_en;
  logic active_q, valid_q;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    ram_rdata, rdata_q;

  assign sel    = !ce1_ni && ce2_i && !ce3_ni;
  assign cpu_go = !ads_cpu_ni && !ce1_ni;   // processor strobe masked by ce1
  assign ctl_go = !ads_ctl_ni;
  assign start  = (cpu_go || ctl_go) && !sleep_i;
  assign is_wr  = !gw_ni || (!bwe_ni && !(&bw_ni));
  assign lane_en = !gw_ni ? '1 : ~bw_ni;

  assign load  = start && sel;
  assign desel = start && !sel;
  assign cont  = !sleep_i && !start && active_q;
  assign step  = cont && !adv_ni;
  assign rd_en = (load && (cpu_go || !is_wr)) || (cont && !is_wr);
  assign wr_en = (load && !cpu_go && is_wr) || (cont && is_wr);

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .mode_i    (mode_i),
    .addr_i    (addr_i),
    .acc_addr_o(acc_addr)
  );

  byte_lane_ram #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW)) u_ram (
    .clk_i    (clk_i),
    .we_i     (wr_en),
    .lane_en_i(lane_en),
    .addr_i   (acc_addr),
    .wdata_i  (wdata_i),
    .rdata_o  (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      rdata_q  <= '0;
    end else if (!sleep_i) begin
      if (load) active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      valid_q <= rd_en;
      if (rd_en) rdata_q <= ram_rdata;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_drive_o = valid_q && !oe_ni;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int unsigned LANES = 2,
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             ads_cpu_ni,
  input logic             ads_ctl_ni,
  input logic             adv_ni,
  input logic             ce1_ni,
  input logic             ce2_i,
  input logic             ce3_ni,
  input logic             gw_ni,
  input logic             bwe_ni,
  input logic [LANES-1:0] bw_ni,
  input logic             mode_i,
  input logic             oe_ni,
  input logic             sleep_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             rd_drive_o
);
  logic sel_c, wr_c, start_c;
  assign sel_c   = !ce1_ni && ce2_i && !ce3_ni;
  assign wr_c    = !gw_ni || (!bwe_ni && (bw_ni != '1));
  assign start_c = !ads_ctl_ni || (!ads_cpu_ni && !ce1_ni);

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && start_c && !sel_c) |=> !rd_drive_o); // R1

  AST_CPU_START_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !ads_cpu_ni && sel_c) |=> (oe_ni || rd_drive_o)); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && ads_cpu_ni && !ads_ctl_ni && sel_c && wr_c) |=> !rd_drive_o); // R6

  AST_OE_FORCES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rd_drive_o); // R10

  AST_SLEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(rdata_o)); // R11
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES), .AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .ads_cpu_ni(ads_cpu_ni),
  .ads_ctl_ni(ads_ctl_ni), .adv_ni(adv_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
  .ce3_ni(ce3_ni), .gw_ni(gw_ni), .bwe_ni(bwe_ni), .bw_ni(bw_ni), .mode_i(mode_i),
  .oe_ni(oe_ni), .sleep_i(sleep_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .rd_drive_o(rd_drive_o)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int DEPTH = 64;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = LANES * LW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ads_cpu_n = 1, ads_ctl_n = 1, adv_n = 1, ce1_n = 0, ce2 = 1, ce3_n = 0;
  logic gw_n = 1, bwe_n = 1, mode = 0, oe_n = 0, slp = 0;
  logic [LANES-1:0] bw_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic drive;

  int checks = 0, errors = 0;
  string cur_req = "R8";

  always #10 clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LW(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ads_cpu_ni(ads_cpu_n),
    .ads_ctl_ni(ads_ctl_n), .adv_ni(adv_n), .ce1_ni(ce1_n), .ce2_i(ce2),
    .ce3_ni(ce3_n), .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .mode_i(mode),
    .oe_ni(oe_n), .sleep_i(slp), .wdata_i(wdata), .rdata_o(rdata), .rd_drive_o(drive)
  );

  // reference state
  logic [DW-1:0] m_mem [DEPTH];
  logic m_act = 0, m_valid = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [DW-1:0] m_data = '0;

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(16'h5A00 + i * 37);
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input logic [1:0] n,
                                             input logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ n) : (b[1:0] + n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit cpu, ctl, sel, wr, rd, wk;
    logic [AW-1:0] a;
    if (slp) return;
    cpu = !ads_cpu_n && !ce1_n;
    ctl = !ads_ctl_n;
    sel = !ce1_n && ce2 && !ce3_n;
    wr  = !gw_n || (!bwe_n && bw_n != '1);
    rd = 0; wk = 0; a = '0;
    if (cpu || ctl) begin
      if (sel) begin
        m_base = addr; m_cnt = 0; m_act = 1; a = addr;
        if (cpu || !wr) rd = 1; else wk = 1;
      end else m_act = 0;
    end else if (m_act) begin
      if (!adv_n) m_cnt = m_cnt + 1;
      a = beat_addr(m_base, m_cnt, mode);
      if (wr) wk = 1; else rd = 1;
    end
    m_valid = rd;
    if (rd) m_data = m_mem[a];
    if (wk)
      for (int k = 0; k < LANES; k++)
        if (!gw_n || !bw_n[k]) m_mem[a][k*LW +: LW] = wdata[k*LW +: LW];
  endtask

  // one clock: inputs already applied; sample 1 ns after the edge
  task automatic cyc();
    bit exp_drv;
    @(posedge clk); #1;
    model_step();
    exp_drv = m_valid && !oe_n;
    check(drive == exp_drv, cur_req, DW'(drive), DW'(exp_drv));
    if (exp_drv) check(rdata == m_data, cur_req, rdata, m_data);
  endtask

  task automatic quiet();
    ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; slp = 0;
  endtask

  task automatic start_cpu(input logic [AW-1:0] a);
    quiet(); ads_cpu_n = 0; addr = a; cyc();
  endtask

  task automatic next_beat(input logic adv);
    quiet(); adv_n = adv; cyc();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #25;
    checks++;  // R9 reset state
    if (drive !== 1'b0) begin errors++; $display("FAIL R9: actual=%b expected=0", drive); end
    rst_n = 1;
    @(negedge clk);

    // fill array through controller strobe with global write (R7)
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) begin
      quiet(); ads_ctl_n = 0; gw_n = 0; addr = AW'(i); wdata = pat(i); cyc();
    end

    // R4 linear burst from low bits 01
    cur_req = "R4"; mode = 0;
    start_cpu(AW'(13));
    check(rdata == pat(13), "R8", rdata, pat(13));
    next_beat(0); check(rdata == pat(14), "R4", rdata, pat(14));
    next_beat(0); check(rdata == pat(15), "R4", rdata, pat(15));
    next_beat(0); check(rdata == pat(12), "R4", rdata, pat(12));

    // R3 interleaved from low bits 10
    cur_req = "R3"; mode = 1;
    start_cpu(AW'(22));
    next_beat(0); check(rdata == pat(23), "R3", rdata, pat(23));
    next_beat(0); check(rdata == pat(20), "R3", rdata, pat(20));
    // R5 suspend then resume
    cur_req = "R5";
    next_beat(1); check(rdata == pat(20), "R5", rdata, pat(20));
    next_beat(0); check(rdata == pat(21), "R5", rdata, pat(21));

    // R2 cpu strobe with ce1 high is ignored; burst continues
    cur_req = "R2"; mode = 0;
    start_cpu(AW'(40));
    quiet(); ce1_n = 1; ads_cpu_n = 0; addr = AW'(3); adv_n = 0; cyc();
    check(rdata == pat(41) && drive, "R2", rdata, pat(41));
    // cpu strobe with write enables still reads
    quiet(); ads_cpu_n = 0; gw_n = 0; addr = AW'(8); wdata = 16'hDEAD; cyc();
    check(drive && rdata == pat(8), "R2", rdata, pat(8));

    // R7 lane write via byte enables, lane 0 only
    cur_req = "R7";
    quiet(); ads_ctl_n = 0; bwe_n = 0; bw_n = 2'b10; addr = AW'(9); wdata = 16'h1234; cyc();
    check(!drive, "R6", DW'(drive), '0);
    start_cpu(AW'(9));
    check(rdata == {pat(9)[15:8], 8'h34}, "R7", rdata, {pat(9)[15:8], 8'h34});

    // R6 master low, all lanes high: a read
    cur_req = "R6";
    quiet(); ads_ctl_n = 0; bwe_n = 0; bw_n = 2'b11; addr = AW'(30); cyc();
    check(drive && rdata == pat(30), "R6", rdata, pat(30));

    // R1/R9 deselect then stays off
    cur_req = "R1";
    quiet(); ads_ctl_n = 0; ce2 = 0; cyc();
    check(!drive, "R1", DW'(drive), '0);
    cur_req = "R9";
    next_beat(0); check(!drive, "R9", DW'(drive), '0);
    next_beat(0);

    // R10 output enable
    cur_req = "R10";
    start_cpu(AW'(31));
    quiet(); oe_n = 1; adv_n = 1; cyc();
    check(!drive, "R10", DW'(drive), '0);

    // R11 sleep blocks a write, keeps output
    cur_req = "R11";
    start_cpu(AW'(50));
    quiet(); slp = 1; ads_ctl_n = 0; gw_n = 0; addr = AW'(50); wdata = 16'hBEEF; cyc();
    check(rdata == pat(50), "R11", rdata, pat(50));
    start_cpu(AW'(50));
    check(rdata == pat(50), "R11", rdata, pat(50));

    // seeded random in both burst orders
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      cur_req = m ? "R3" : "R4";
      for (int n = 0; n < 3000; n++) begin
        ads_cpu_n = ($urandom % 6) != 0;
        ads_ctl_n = ($urandom % 5) != 0;
        adv_n     = ($urandom % 3) == 0;
        ce1_n     = ($urandom % 8) == 0;
        ce2       = ($urandom % 8) != 0;
        ce3_n     = ($urandom % 10) == 0;
        gw_n      = ($urandom % 4) != 0;
        bwe_n     = $urandom % 2;
        bw_n      = LANES'($urandom);
        oe_n      = ($urandom % 8) == 0;
        slp       = ($urandom % 12) == 0;
        addr      = AW'($urandom);
        wdata     = DW'($urandom);
        cyc();
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule